// File: doc/BRIEF.md
# Two-Channel PWM Register Controller

This block is a memory-mapped slave that stores the settings of two pulse-width channels and drives one pad per channel. It uses a plain 32-bit register port with address, write strobe, write data and read data. A write takes effect at the clock edge on which the strobe is high. Read data follows the address combinationally.

Each channel has two generators. The first is a phase accumulator that adds a step taken from a 16-bit frequency word on every clock. Its top bit is a variable-frequency square wave. The second is a duty counter that advances once per rising edge of that square wave. It produces a constant-frequency pulse train from an 8-bit period and an 8-bit high time.

A shared select register picks which of the two waveforms each channel uses. A 4-bit control field per channel then sets how the pad is driven: run, an active-low enable, force-high, and open-drain or push-pull.

Top module: `pwm_pair_regs`

## Requirements
- R1: After reset the control register at 0x00 reads 0x22, because each channel's active-low enable (bit 4n+1) resets to 1. Every other register reads 0, and both pad enables are deasserted.
- R2: Channel n owns bits 4n..4n+3 of the control register at 0x00: bit 4n is run, bit 4n+1 is the active-low enable, bit 4n+2 is force-high and bit 4n+3 is open-drain. Bits 8 to 31 read 0.
- R3: In the select register at 0x04, bit 4n set makes channel n output the constant-frequency waveform, and bit 4n clear makes it output the variable-frequency waveform. Every other bit reads 0.
- R4: Channel n has four 8-bit registers, each holding the low 8 bits of the write data: the frequency word high byte at 0x08+8n, the low byte at 0x0C+8n, the high time at 0x18+8n and the period at 0x1C+8n. Bits 8 to 31 read 0.
- R5: While run is set, the accumulator adds a step W on every clock. W is the word when the word is below 0x8000, and 65536 minus the word otherwise. The variable-frequency output is the accumulator's top bit, so a power-of-two W gives a 50 % square wave of 65536/W clocks, and W = 0 gives a constant low.
- R6: The duty counter advances on each rising edge of the variable-frequency wave. It counts from 0 up to the period value and then wraps to 0. The constant-frequency output is high while the count is below the high time, so it is high for min(on, period+1) of every period+1 edges.
- R7: While run is clear, both generators are held at zero and the channel level is low, unless force-high is set.
- R8: Force-high makes the channel level 1 whatever the run and select settings.
- R9: In push-pull mode (open-drain clear), the pad enable is the inverse of the active-low enable and the pad data is the channel level.
- R10: In open-drain mode, the pad data is 0 and the pad enable is asserted only while the active-low enable is 0 and the level is low.
- R11: Reads of an address outside the map return 0, and writes to such an address change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_o | output | 2 | Pad data, one bit per channel |
| pad_oe | output | 2 | Pad output enable, one bit per channel |

## Verification
Read data depends only on the address and the stored registers. The bench therefore samples it a moment after presenting the address, half a clock away from any edge. A written value becomes visible just after the edge that captures the strobe, and the pad outputs follow register and generator state with no extra stage. Both generators restart from zero whenever run is raised, so each waveform is periodic from that edge on. The bench counts high samples and rising edges over a window of whole periods, which makes the expected counts exact whatever the start phase. The sweeps cover the high time and the period, several frequency words on both sides of 0x8000, and every pad mode.

// File: rtl/pwm_pair_pkg.sv
// pwm_pair_pkg: shared types and the register map of the two-channel PWM
// controller. Assumes byte addressing with one 32-bit register per word.
package pwm_pair_pkg;

    // Per-channel control field, bit 0 (run) up to bit 3 (open-drain).
    typedef struct packed {
        logic od;        // bit 3: open-drain drive
        logic force_hi;  // bit 2: force the level high
        logic oe_n;      // bit 1: active-low pad enable
        logic run;       // bit 0: generators running
    } chan_ctl_t;

    localparam chan_ctl_t CTL_RST = 4'b0010;

    localparam int NIB      = 4;    // control bits per channel
    localparam int CTL_OFS  = 0;    // shared control register
    localparam int SEL_OFS  = 4;    // shared output-select register
    localparam int STRIDE   = 8;    // per-channel register spacing
    localparam int WHI_BASE = 8;    // frequency word upper byte
    localparam int WLO_BASE = 12;   // frequency word lower byte
    localparam int ON_BASE  = 24;   // high-time count
    localparam int PER_BASE = 28;   // period count

endpackage

// File: rtl/pwm_pair_regfile.sv
// pwm_pair_regfile: holds the control, select and per-channel registers and
// drives combinational read data. Assumes NCH <= 2, because the per-channel
// blocks of more channels would overlap in the address map.
module pwm_pair_regfile
    import pwm_pair_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int CW_W  = 16,
    parameter int CNT_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [AW-1:0]                  bus_addr,
    input  logic                           bus_we,
    input  logic [DW-1:0]                  bus_wdata,
    output logic [DW-1:0]                  bus_rdata,
    output chan_ctl_t [NCH-1:0]            ctl_o,
    output logic [NCH-1:0]                 sel_o,
    output logic [NCH-1:0][CW_W-1:0]       cword_o,
    output logic [NCH-1:0][CNT_W-1:0]      on_o,
    output logic [NCH-1:0][CNT_W-1:0]      per_o
);
    localparam int HB    = CW_W / 2;
    localparam int CTL_W = NIB * NCH;

    chan_ctl_t [NCH-1:0]        ctl_q;
    logic [NCH-1:0]             sel_q;
    logic [NCH-1:0][HB-1:0]     whi_q;
    logic [NCH-1:0][HB-1:0]     wlo_q;
    logic [NCH-1:0][CNT_W-1:0]  on_q;
    logic [NCH-1:0][CNT_W-1:0]  per_q;
    logic                       unused_wdata;

    assign unused_wdata = ^bus_wdata[DW-1:CTL_W];

    // Address comparison for one register of one channel.
    function automatic logic hit(input logic [AW-1:0] a, input int base, input int ch);
        return a == AW'(base + STRIDE * ch);
    endfunction

    // Shared control and select registers: reset, then write on a matching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NCH; ch++) ctl_q[ch] <= CTL_RST;
            sel_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == AW'(CTL_OFS)) ctl_q <= bus_wdata[CTL_W-1:0];
            if (bus_addr == AW'(SEL_OFS))
                for (int ch = 0; ch < NCH; ch++) sel_q[ch] <= bus_wdata[NIB*ch];
        end
    end

    // Per-channel word, high-time and period registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            whi_q <= '0;
            wlo_q <= '0;
            on_q  <= '0;
            per_q <= '0;
        end else if (bus_we) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (hit(bus_addr, WHI_BASE, ch)) whi_q[ch] <= bus_wdata[HB-1:0];
                if (hit(bus_addr, WLO_BASE, ch)) wlo_q[ch] <= bus_wdata[HB-1:0];
                if (hit(bus_addr, ON_BASE, ch))  on_q[ch]  <= bus_wdata[CNT_W-1:0];
                if (hit(bus_addr, PER_BASE, ch)) per_q[ch] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // Read multiplexer: stored values, with unused bits and unmapped addresses at 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(CTL_OFS)) bus_rdata[CTL_W-1:0] = ctl_q;
        if (bus_addr == AW'(SEL_OFS))
            for (int ch = 0; ch < NCH; ch++) bus_rdata[NIB*ch] = sel_q[ch];
        for (int ch = 0; ch < NCH; ch++) begin
            if (hit(bus_addr, WHI_BASE, ch)) bus_rdata[HB-1:0]    = whi_q[ch];
            if (hit(bus_addr, WLO_BASE, ch)) bus_rdata[HB-1:0]    = wlo_q[ch];
            if (hit(bus_addr, ON_BASE, ch))  bus_rdata[CNT_W-1:0] = on_q[ch];
            if (hit(bus_addr, PER_BASE, ch)) bus_rdata[CNT_W-1:0] = per_q[ch];
        end
    end

    // Outputs to the channel logic.
    always_comb begin
        ctl_o = ctl_q;
        sel_o = sel_q;
        on_o  = on_q;
        per_o = per_q;
        for (int ch = 0; ch < NCH; ch++) cword_o[ch] = {whi_q[ch], wlo_q[ch]};
    end

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == AW'(CTL_OFS) |=> ctl_q == $past(bus_wdata[CTL_W-1:0]));

    // R4
    on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == AW'(ON_BASE) |=> on_q[0] == $past(bus_wdata[CNT_W-1:0]));

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr >= AW'(PER_BASE + STRIDE * NCH) |-> bus_rdata == '0);

endmodule

// File: rtl/pwm_phase_gen.sv
// pwm_phase_gen: phase accumulator that makes the variable-frequency wave.
// The step is the word itself below half scale, otherwise its two's
// complement. Held at zero while run is clear. Assumes CW_W >= 2.
module pwm_phase_gen #(
    parameter int CW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [CW_W-1:0] cword,
    output logic            vf_o,
    output logic            tick_o
);
    logic [CW_W-1:0] acc_q;
    logic [CW_W-1:0] step;
    logic [CW_W-1:0] sum;

    // Step selection and next phase.
    always_comb begin
        step   = cword[CW_W-1] ? (~cword + 1'b1) : cword;
        sum    = acc_q + step;
        tick_o = run & ~acc_q[CW_W-1] & sum[CW_W-1];
        vf_o   = acc_q[CW_W-1];
    end

    // Phase register: cleared by reset or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) acc_q <= '0;
        else                acc_q <= sum;
    end

    // R7
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !vf_o);

    // R5
    tick_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> vf_o);

endmodule

// File: rtl/pwm_duty_gen.sv
// pwm_duty_gen: counter that advances once per tick, wraps after the period
// value, and is high while below the high time. Held at zero while run is
// clear. A period lowered below the current count wraps at the next tick.
module pwm_duty_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] on_cnt,
    input  logic [CNT_W-1:0] per_cnt,
    output logic             cf_o
);
    logic [CNT_W-1:0] cnt_q;

    // Position counter: wraps after the period value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   cnt_q <= '0;
        else if (tick)        cnt_q <= (cnt_q >= per_cnt) ? '0 : cnt_q + 1'b1;
    end

    // Output compare.
    assign cf_o = cnt_q < on_cnt;

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(per_cnt) && cnt_q <= per_cnt |=> cnt_q <= per_cnt);

    // R6
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_pad_drv.sv
// pwm_pad_drv: selects the waveform, applies run and force-high, and drives
// the pad in push-pull or open-drain mode. Purely combinational; the clock
// serves only the checks.
module pwm_pad_drv
    import pwm_pair_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_ctl_t ctl,
    input  logic      sel_cf,
    input  logic      vf,
    input  logic      cf,
    output logic      pad_o,
    output logic      pad_oe
);
    logic level;

    // Channel level, then pad data and enable for the chosen drive mode.
    always_comb begin
        level = ctl.force_hi | (ctl.run & (sel_cf ? cf : vf));
        if (ctl.od) begin
            pad_o  = 1'b0;
            pad_oe = ~ctl.oe_n & ~level;
        end else begin
            pad_o  = level;
            pad_oe = ~ctl.oe_n;
        end
    end

    // R8
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.force_hi && !ctl.od |-> pad_o);

    // R7
    stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.run && !ctl.force_hi && !ctl.od |-> !pad_o);

    // R10
    od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.od |-> !pad_o && !(ctl.force_hi && pad_oe));

endmodule

// File: rtl/pwm_pair_regs.sv
// pwm_pair_regs: top of the two-channel PWM controller. The register file
// feeds one phase generator, one duty generator and one pad driver per
// channel. Assumes single-cycle register access on one clock.
module pwm_pair_regs
    import pwm_pair_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int CW_W  = 16,
    parameter int CNT_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_we,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pad_o,
    output logic [NCH-1:0] pad_oe
);
    chan_ctl_t [NCH-1:0]        ctl;
    logic [NCH-1:0]             sel;
    logic [NCH-1:0][CW_W-1:0]   cword;
    logic [NCH-1:0][CNT_W-1:0]  on_cnt;
    logic [NCH-1:0][CNT_W-1:0]  per_cnt;
    logic [NCH-1:0]             vf;
    logic [NCH-1:0]             tick;
    logic [NCH-1:0]             cf;

    pwm_pair_regfile #(
        .NCH(NCH), .AW(AW), .DW(DW), .CW_W(CW_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ctl_o    (ctl),
        .sel_o    (sel),
        .cword_o  (cword),
        .on_o     (on_cnt),
        .per_o    (per_cnt)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pwm_phase_gen #(.CW_W(CW_W)) u_phase (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (ctl[ch].run),
            .cword (cword[ch]),
            .vf_o  (vf[ch]),
            .tick_o(tick[ch])
        );

        pwm_duty_gen #(.CNT_W(CNT_W)) u_duty (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (ctl[ch].run),
            .tick   (tick[ch]),
            .on_cnt (on_cnt[ch]),
            .per_cnt(per_cnt[ch]),
            .cf_o   (cf[ch])
        );

        pwm_pad_drv u_pad (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl[ch]),
            .sel_cf(sel[ch]),
            .vf    (vf[ch]),
            .cf    (cf[ch]),
            .pad_o (pad_o[ch]),
            .pad_oe(pad_oe[ch])
        );
    end

endmodule

// File: tb/tb_pwm_pair_regs.sv
// tb_pwm_pair_regs: register and waveform sweeps with arithmetic expectations.
module tb_pwm_pair_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pad_o;
    logic [1:0]  pad_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwm_pair_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input longint d);
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = 32'(d); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input int a, input longint exp);
        @(negedge clk);
        bus_addr = 8'(a);
        #1 chk(req, bus_rdata, exp);
    endtask

    // Counts high data, high enable and rising data edges over n samples.
    task automatic measure(input int ch, input int n, output int hi, output int oe, output int ri);
        logic prev;
        hi = 0; oe = 0; ri = 0;
        @(negedge clk);
        prev = pad_o[ch];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pad_o[ch]) hi++;
            if (pad_oe[ch]) oe++;
            if (pad_o[ch] && !prev) ri++;
            prev = pad_o[ch];
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hi, oe, ri, w;
        int cw_list [6] = '{32'h8000, 32'h4000, 32'h2000, 32'hE000, 32'hC000, 32'h0000};
        wait_cyc(4);
        rst_n = 1'b1;
        // R1 reset values
        rd("R1 ctl", 0, 32'h22);
        rd("R1 sel", 4, 0);
        rd("R1 word hi ch0", 8, 0);
        rd("R1 on ch1", 32, 0);
        #1 chk("R1 pad_oe", pad_oe, 0);
        // R2 and R3 field widths
        wr(0, 32'hFFFF_FFFF);  rd("R2 ctl mask", 0, 32'hFF);
        wr(0, 32'h0000_005A);  rd("R2 ctl value", 0, 32'h5A);
        wr(4, 32'hFFFF_FFFF);  rd("R3 sel mask", 4, 32'h11);
        wr(4, 0);
        // R4 per-channel registers
        for (int ch = 0; ch < 2; ch++) begin
            int bases [4] = '{8, 12, 24, 28};
            for (int k = 0; k < 4; k++) begin
                int v = (8'hA5 ^ (ch * 16 + k)) & 8'hFF;
                wr(bases[k] + 8 * ch, 32'hFFFF_FF00 | v);
                rd("R4 readback", bases[k] + 8 * ch, v);
            end
        end
        // R11 unmapped
        wr(0, 32'h22);
        wr(8'h40, 32'hFFFF_FFFF);
        rd("R11 unmapped read", 8'h40, 0);
        rd("R11 unmapped read 0x28", 8'h28, 0);
        rd("R11 ctl untouched", 0, 32'h22);
        rd("R11 sel untouched", 4, 0);
        // R5 variable frequency on channel 0
        for (int i = 0; i < 6; i++) begin
            int c = cw_list[i];
            wr(0, 0); wr(4, 0);
            wr(8, c >> 8); wr(12, c & 8'hFF);
            wr(0, 32'h01);
            wait_cyc(3);
            w = (c >= 32768) ? 65536 - c : c;
            measure(0, 64, hi, oe, ri);
            chk("R5 vf high count", hi, (w == 0) ? 0 : 32);
            chk("R5 vf edges", ri, (64 * w) / 65536);
        end
        // R6 constant frequency sweep, vf period 4 clocks
        wr(8, 8'h40); wr(12, 0); wr(4, 32'h01);
        for (int p = 0; p < 4; p++) begin
            for (int o = 0; o < 5; o++) begin
                wr(0, 0); wr(24, o); wr(28, p);
                wr(0, 32'h01);
                wait_cyc(3);
                measure(0, 8 * (p + 1), hi, oe, ri);
                chk("R6 cf high count", hi, 8 * ((o < p + 1) ? o : p + 1));
            end
        end
        // R7 stopped, push-pull enabled
        wr(0, 0);
        measure(0, 16, hi, oe, ri);
        chk("R7 stopped low", hi, 0);
        chk("R9 pp oe on", oe, 16);
        // R8 force high
        wr(0, 32'h05);
        measure(0, 16, hi, oe, ri);
        chk("R8 force with run", hi, 16);
        wr(0, 32'h04);
        measure(0, 16, hi, oe, ri);
        chk("R8 force stopped", hi, 16);
        // R9 push-pull with enable off
        wr(4, 0);
        wr(0, 32'h03);
        measure(0, 64, hi, oe, ri);
        chk("R9 pp oe off", oe, 0);
        chk("R9 pp data follows level", hi, 32);
        // R10 open drain
        wr(0, 32'h09);
        measure(0, 64, hi, oe, ri);
        chk("R10 od data", hi, 0);
        chk("R10 od oe low half", oe, 32);
        wr(0, 32'h0B);
        measure(0, 64, hi, oe, ri);
        chk("R10 od disabled", oe, 0);
        wr(0, 32'h0D);
        measure(0, 16, hi, oe, ri);
        chk("R10 od forced high released", oe, 0);
        // R2 channel 1 nibble, channel 0 stopped
        wr(0, 0); wr(4, 0);
        wr(16, 8'h80); wr(20, 0);
        wr(0, 32'h10);
        wait_cyc(3);
        measure(1, 64, hi, oe, ri);
        chk("R2 ch1 high", hi, 32);
        chk("R5 ch1 edges", ri, 32);
        measure(0, 16, hi, oe, ri);
        chk("R2 ch0 quiet", hi, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule